// File: doc/BRIEF.md
# Programmable External Interrupt Front End

This block sits between 32 external interrupt wires and a downstream interrupt controller that only accepts active-high level requests. Each line has its own settings. Software picks level or edge detection and the active sense: high or rising, or low or falling. The block turns every input into a clean active-high level request on its own output wire. An edge event is held in a per-line request latch until software clears it. A software-set register can also raise that latch.

Software uses a small word-addressed register port. It has a write strobe, a 3-bit word index (byte offset = index × 4) and a combinational read path. Per-line mask bits gate the outputs. Software can read both the unmasked (raw) request view and the masked (pending) request view. An event that arrives while its line is masked is still recorded, so software can clear it before unmasking. Every per-line register puts line n at bit n. Every input passes through a synchronizer before detection.

Top module: `ext_irq_unit`

## Requirements
- R1: After reset the mask register reads all ones, the polarity register reads all ones, the edge-select and source-select registers read zero, all request latches are zero and `irqOut` is zero.
- R2: Register word indices are: 0 mask, 1 source select, 2 pending (masked) status, 3 raw status, 4 request clear, 5 polarity, 6 edge select, 7 software set. Mask, source select, polarity and edge select read back what was written. Indices 4 and 7 read as zero.
- R3: With edge-select bit 0 (level mode), raw status bit n is 1 while synchronized input n equals polarity bit n, i.e. high when polarity is 1 and low when polarity is 0. It follows the input within two clock edges.
- R4: With edge-select bit 1, a rising input (polarity 1) or a falling input (polarity 0) sets line n's request latch. The latch stays set after the input returns.
- R5: Writing 1 to bit n of the clear register (index 4) clears line n's request latch. Bits written as 0 leave their latches unchanged. A latch never clears without such a write.
- R6: Pending status equals raw status AND NOT mask, and `irqOut` equals pending status. A mask bit of 1 forces that output to 0.
- R7: An event on a masked line still sets its latch and appears in raw status. If it is cleared before the line is unmasked, no output pulse appears.
- R8: In level mode, a clear write has no lasting effect while the input level is still active.
- R9: Writing 1 to bit n of the software-set register (index 7) sets line n's request latch in either mode. The request appears in raw status on the following cycle.
- R10: The source-select register is plain storage and does not affect any status bit or output.
- R11: In edge mode, a transition in the non-selected direction does not set the latch. Changing polarity while the input is steady does not set it either.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| wrEn | input | 1 | Single-cycle register write strobe |
| regAddr | input | 3 | Register word index for reads and writes |
| wrData | input | 32 | Write data, bit n for line n |
| rdData | output | 32 | Combinational read data for `regAddr` |
| irqIn | input | 32 | External interrupt lines (asynchronous) |
| irqOut | output | 32 | Active-high level requests to the downstream controller |

## Verification
The hardest case to reach from the ports is a request latched while its line is masked and then removed before the mask drops. The masked output never shows it, so only the raw-status read reveals the latch. The stimulus masks a line in edge mode and pulses the input long enough to pass the synchronizer. It then reads raw and pending status, clears the line, unmasks it and checks that the output stays low. A second pass leaves out the clear and shows that the request survives the unmask. Level-mode clear, opposite-direction edges and polarity flips under a steady input are driven in the same way, with every wait longer than the synchronizer delay.

// File: rtl/eiu_pkg.sv
package eiu_pkg;

  typedef enum logic [2:0] {
    RegMask     = 3'd0,
    RegSrcSel   = 3'd1,
    RegPend     = 3'd2,
    RegRaw      = 3'd3,
    RegClear    = 3'd4,
    RegPolarity = 3'd5,
    RegEdgeSel  = 3'd6,
    RegSwSet    = 3'd7
  } regIdx_e;

  typedef struct packed {
    logic mask;
    logic srcSel;
    logic clear;
    logic polarity;
    logic edgeSel;
    logic swSet;
  } wrStrobe_t;

endpackage

// File: rtl/eiu_ctrl.sv
module eiu_ctrl
  import eiu_pkg::*;
(
  input  logic       wrEn,
  input  logic [2:0] regAddr,
  output wrStrobe_t  wrStb,
  output regIdx_e    rdIdx
);

  regIdx_e idx;
  assign idx   = regIdx_e'(regAddr);
  assign rdIdx = idx;

  always_comb begin
    wrStb = '0;
    if (wrEn) begin
      case (idx)
        RegMask:     wrStb.mask     = 1'b1;
        RegSrcSel:   wrStb.srcSel   = 1'b1;
        RegClear:    wrStb.clear    = 1'b1;
        RegPolarity: wrStb.polarity = 1'b1;
        RegEdgeSel:  wrStb.edgeSel  = 1'b1;
        RegSwSet:    wrStb.swSet    = 1'b1;
        default:     wrStb          = '0;
      endcase
    end
  end

endmodule

// File: rtl/eiu_datapath.sv
module eiu_datapath
  import eiu_pkg::*;
#(
  parameter int NUM_LINES  = 32,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  wrStrobe_t            wrStb,
  input  regIdx_e              rdIdx,
  input  logic [NUM_LINES-1:0] wrData,
  input  logic [NUM_LINES-1:0] irqIn,
  output logic [NUM_LINES-1:0] rdData,
  output logic [NUM_LINES-1:0] irqOut,
  output logic [NUM_LINES-1:0] latchQ,
  output logic [NUM_LINES-1:0] evtVec
);

  localparam int LAST = SYNC_DEPTH - 1;

  logic [NUM_LINES-1:0] syncQ [SYNC_DEPTH];
  logic [NUM_LINES-1:0] prevQ;
  logic [NUM_LINES-1:0] maskQ, srcSelQ, polQ, edgeQ;
  logic [NUM_LINES-1:0] sampleNow, levelAct, riseVec, fallVec;
  logic [NUM_LINES-1:0] clrBits, setBits, latchD, rawStat, pendStat;

  // input synchronizer chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= '0;
    else       syncQ[0] <= irqIn;
  end

  for (genvar s = 1; s < SYNC_DEPTH; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[s] <= '0;
      else       syncQ[s] <= syncQ[s-1];
    end
  end

  assign sampleNow = syncQ[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= sampleNow;
  end

  // configuration storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ   <= '1;
      srcSelQ <= '0;
      polQ    <= '1;
      edgeQ   <= '0;
    end else begin
      if (wrStb.mask)     maskQ   <= wrData;
      if (wrStb.srcSel)   srcSelQ <= wrData;
      if (wrStb.polarity) polQ    <= wrData;
      if (wrStb.edgeSel)  edgeQ   <= wrData;
    end
  end

  // detection
  assign levelAct = ~(sampleNow ^ polQ);
  assign riseVec  = sampleNow & ~prevQ;
  assign fallVec  = ~sampleNow & prevQ;
  assign evtVec   = edgeQ & ((polQ & riseVec) | (~polQ & fallVec));

  // request latch: new events and software sets win over a clear
  assign clrBits = wrStb.clear ? wrData : '0;
  assign setBits = wrStb.swSet ? wrData : '0;
  assign latchD  = (latchQ & ~clrBits) | evtVec | setBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) latchQ <= '0;
    else       latchQ <= latchD;
  end

  assign rawStat  = latchQ | (~edgeQ & levelAct);
  assign pendStat = rawStat & ~maskQ;
  assign irqOut   = pendStat;

  always_comb begin
    case (rdIdx)
      RegMask:     rdData = maskQ;
      RegSrcSel:   rdData = srcSelQ;
      RegPend:     rdData = pendStat;
      RegRaw:      rdData = rawStat;
      RegPolarity: rdData = polQ;
      RegEdgeSel:  rdData = edgeQ;
      default:     rdData = '0;
    endcase
  end

endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit
  import eiu_pkg::*;
#(
  parameter int NUM_LINES  = 32,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [2:0]           regAddr,
  input  logic [NUM_LINES-1:0] wrData,
  output logic [NUM_LINES-1:0] rdData,
  input  logic [NUM_LINES-1:0] irqIn,
  output logic [NUM_LINES-1:0] irqOut
);

  wrStrobe_t            wrStb;
  regIdx_e              rdIdx;
  logic [NUM_LINES-1:0] latchQ, evtVec;

  eiu_ctrl u_ctl (
    .wrEn    (wrEn),
    .regAddr (regAddr),
    .wrStb   (wrStb),
    .rdIdx   (rdIdx)
  );

  eiu_datapath #(
    .NUM_LINES  (NUM_LINES),
    .SYNC_DEPTH (SYNC_DEPTH)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .wrStb  (wrStb),
    .rdIdx  (rdIdx),
    .wrData (wrData),
    .irqIn  (irqIn),
    .rdData (rdData),
    .irqOut (irqOut),
    .latchQ (latchQ),
    .evtVec (evtVec)
  );

endmodule

// File: rtl/eiu_checker.sv
module eiu_checker
  import eiu_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrEn,
  input logic [2:0]           regAddr,
  input logic [NUM_LINES-1:0] wrData,
  input logic [NUM_LINES-1:0] irqOut,
  input logic [NUM_LINES-1:0] latchQ,
  input logic [NUM_LINES-1:0] evtVec
);

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (irqOut == '0 && latchQ == '0));

  a_r6_full_mask_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == RegMask && wrData == '1) |=> irqOut == '0);

  a_r4_event_latches: assert property (@(posedge clk) disable iff (!rstN)
    (evtVec != '0) |=> ((latchQ & $past(evtVec)) == $past(evtVec)));

  a_r5_clear_takes: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == RegClear) |=>
      ((latchQ & $past(wrData) & ~$past(evtVec)) == '0));

  a_r5_no_silent_drop: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && regAddr == RegClear) |=> (($past(latchQ) & ~latchQ) == '0));

  a_r9_swset_takes: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == RegSwSet) |=>
      ((latchQ & $past(wrData)) == $past(wrData)));

endmodule

bind ext_irq_unit eiu_checker #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .regAddr (regAddr),
  .wrData  (wrData),
  .irqOut  (irqOut),
  .latchQ  (u_dp.latchQ),
  .evtVec  (u_dp.evtVec)
);

// File: tb/sim_ext_irq_unit.sv
module sim_ext_irq_unit;

  localparam logic [2:0] IX_MASK = 3'd0, IX_SRC = 3'd1, IX_PEND = 3'd2,
                         IX_RAW = 3'd3, IX_CLR = 3'd4, IX_POL = 3'd5,
                         IX_EDGE = 3'd6, IX_SW = 3'd7;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [31:0] irqIn = '0;
  logic [31:0] irqOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ext_irq_unit u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr),
    .wrData(wrData), .rdData(rdData), .irqIn(irqIn), .irqOut(irqOut)
  );

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] idx, logic [31:0] d);
    wrEn = 1'b1; regAddr = idx; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(logic [2:0] idx, output logic [31:0] d);
    regAddr = idx;
    #1;
    d = rdData;
  endtask

  task automatic expectReg(string tag, logic [2:0] idx, logic [31:0] exp);
    logic [31:0] v;
    rd(idx, v);
    check(tag, v, exp);
  endtask

  task automatic testReset();
    expectReg("R1 mask", IX_MASK, 32'hFFFF_FFFF);
    expectReg("R1 polarity", IX_POL, 32'hFFFF_FFFF);
    expectReg("R1 edge", IX_EDGE, 32'h0);
    expectReg("R1 srcsel", IX_SRC, 32'h0);
    expectReg("R1 raw", IX_RAW, 32'h0);
    expectReg("R1 pend", IX_PEND, 32'h0);
    check("R1 irqOut", irqOut, 32'h0);
    expectReg("R2 clear reads zero", IX_CLR, 32'h0);
    expectReg("R2 swset reads zero", IX_SW, 32'h0);
  endtask

  task automatic testLevelHigh();
    wr(IX_MASK, ~32'h8);
    irqIn = 32'h18;
    step(1);
    check("R3 no early level", irqOut, 32'h0);
    step(2);
    expectReg("R3 raw high level", IX_RAW, 32'h18);
    expectReg("R6 pend masked", IX_PEND, 32'h8);
    check("R6 irqOut", irqOut, 32'h8);
    irqIn = '0;
    step(3);
    check("R3 level drops", irqOut, 32'h0);
    expectReg("R3 raw drops", IX_RAW, 32'h0);
  endtask

  task automatic testLevelLow();
    wr(IX_POL, ~32'h20);
    step(1);
    expectReg("R3 raw low level", IX_RAW, 32'h20);
    wr(IX_CLR, 32'h20);
    step(2);
    expectReg("R8 clear while active", IX_RAW, 32'h20);
    irqIn[5] = 1'b1;
    step(3);
    expectReg("R3 low level released", IX_RAW, 32'h0);
    wr(IX_POL, 32'hFFFF_FFFF);
    irqIn[5] = 1'b0;
    step(3);
    expectReg("R3 restore", IX_RAW, 32'h0);
  endtask

  task automatic testRising();
    wr(IX_EDGE, 32'h80);
    wr(IX_MASK, ~32'h80);
    irqIn[7] = 1'b1;
    step(4);
    check("R4 rising latched out", irqOut, 32'h80);
    irqIn[7] = 1'b0;
    step(4);
    expectReg("R4 stays latched", IX_RAW, 32'h80);
    wr(IX_CLR, ~32'h80);
    expectReg("R5 zero bit no effect", IX_RAW, 32'h80);
    wr(IX_CLR, 32'h80);
    expectReg("R5 clear raw", IX_RAW, 32'h0);
    check("R5 clear out", irqOut, 32'h0);
    irqIn[7] = 1'b1;
    step(4);
    wr(IX_CLR, 32'h80);
    irqIn[7] = 1'b0;
    step(4);
    expectReg("R11 falling ignored in rising mode", IX_RAW, 32'h0);
  endtask

  task automatic testFalling();
    wr(IX_POL, ~32'h200);
    wr(IX_EDGE, 32'h200);
    irqIn[9] = 1'b1;
    step(4);
    expectReg("R11 rising ignored in falling mode", IX_RAW, 32'h0);
    wr(IX_POL, 32'hFFFF_FFFF);
    step(2);
    expectReg("R11 polarity flip no latch", IX_RAW, 32'h0);
    wr(IX_POL, ~32'h200);
    irqIn[9] = 1'b0;
    step(4);
    expectReg("R4 falling latched", IX_RAW, 32'h200);
    wr(IX_CLR, 32'h200);
    expectReg("R5 falling cleared", IX_RAW, 32'h0);
    wr(IX_POL, 32'hFFFF_FFFF);
  endtask

  task automatic testMaskedLatch();
    wr(IX_EDGE, 32'h1000);
    wr(IX_MASK, 32'hFFFF_FFFF);
    irqIn[12] = 1'b1;
    step(4);
    irqIn[12] = 1'b0;
    step(4);
    expectReg("R7 raw while masked", IX_RAW, 32'h1000);
    expectReg("R7 pend while masked", IX_PEND, 32'h0);
    check("R7 out while masked", irqOut, 32'h0);
    wr(IX_CLR, 32'h1000);
    wr(IX_MASK, ~32'h1000);
    check("R7 no output after clear and unmask", irqOut, 32'h0);
    step(2);
    check("R7 still quiet", irqOut, 32'h0);
    wr(IX_MASK, 32'hFFFF_FFFF);
    irqIn[12] = 1'b1;
    step(4);
    irqIn[12] = 1'b0;
    step(4);
    wr(IX_MASK, ~32'h1000);
    check("R7 kept request shows on unmask", irqOut, 32'h1000);
    wr(IX_CLR, 32'h1000);
    check("R5 cleared after unmask", irqOut, 32'h0);
    wr(IX_MASK, 32'hFFFF_FFFF);
  endtask

  task automatic testSwSet();
    wr(IX_EDGE, 32'h0020_0000);
    wr(IX_MASK, ~32'h0030_0000);
    wr(IX_SW, 32'h0030_0000);
    expectReg("R9 swset raw", IX_RAW, 32'h0030_0000);
    check("R9 swset out", irqOut, 32'h0030_0000);
    wr(IX_CLR, 32'h0030_0000);
    expectReg("R9 swset cleared", IX_RAW, 32'h0);
    wr(IX_EDGE, 32'h0);
    wr(IX_MASK, 32'hFFFF_FFFF);
  endtask

  task automatic testStorage();
    wr(IX_MASK, 32'h0);
    wr(IX_SRC, 32'hA5A5_5A5A);
    expectReg("R2 srcsel readback", IX_SRC, 32'hA5A5_5A5A);
    step(2);
    check("R10 srcsel no output effect", irqOut, 32'h0);
    expectReg("R10 srcsel no status effect", IX_RAW, 32'h0);
    wr(IX_EDGE, 32'h3C3C_0000);
    expectReg("R2 edge readback", IX_EDGE, 32'h3C3C_0000);
    wr(IX_MASK, 32'h1234_5678);
    expectReg("R2 mask readback", IX_MASK, 32'h1234_5678);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLevelHigh();
    testLevelLow();
    testRising();
    testFalling();
    testMaskedLatch();
    testSwSet();
    testStorage();
    finishRun();
  end

endmodule